// File: doc/BRIEF.md
# Peripheral Bus Clock-Enable Divider

This block derives a single-cycle clock-enable pulse for a peripheral bus from the clock it runs on. The pulse repeats every N+1 cycles, where N is a 7-bit divisor field that software programs through one 32-bit control register. A gate bit in the same register holds the pulse low without stopping the internal period counter, so re-enabling resumes on the running period grid.

The control register has three write views chosen by a 2-bit address: a plain write that replaces the writable bits, a set view that ORs in the bits written as one, and a clear view that removes the bits written as one. A divisor change is a two-step handshake. The write is taken only while the system unlock input is high and the ready flag is high; ready then drops, and the counter switches to the new ratio only when the period under way completes, after which ready rises again. Choosing the divisor for a target frequency is left to software.

Top module: `pbdiv_top`

## Requirements
- R1: After reset the register reads 0x0000_8800 (divisor field 0, gate bit 15 set, ready bit 11 set) and the enable pulse is high on every cycle.
- R2: With divisor field N in bits 6:0 and the gate set, consecutive enable pulses are exactly N+1 cycles apart, for every N from 0 to 127.
- R3: While the gate bit 15 is clear the enable output stays low; setting it again restores pulses at the programmed period.
- R4: An accepted divisor change drops ready (bit 11) on the following cycle; ready rises only once the new ratio is in use, and the field then reads back exactly the written value.
- R5: A write that would change the divisor while ready is low leaves the divisor field unchanged.
- R6: A write that would change the divisor while the unlock input is low leaves the divisor field unchanged and ready high.
- R7: A new divisor takes effect only when the current period ends: the period in progress at the write keeps the old length, and the next one has the new length.
- R8: Write address 0 replaces bits 6:0 and bit 15; address 1 sets only the bits written as one; address 2 clears only the bits written as one; address 3 has no effect.
- R9: Ready is read-only: data written to bit 11 through any view does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_unlock_i | input | 1 | High when divisor writes are permitted |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write view: 0 plain, 1 set, 2 clear, 3 none |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register contents: bit 15 gate, bit 11 ready, bits 6:0 divisor field |
| clk_en_o | output | 1 | Peripheral clock-enable pulse |

## Verification
On every cycle the assertions check that a cleared gate forces the output low, that the divisor field cannot move while ready is low or the unlock is off, that an accepted plain-view change drops ready on the next cycle, and that an enabled output never goes more than 128 cycles without a pulse. Exact pulse spacing for chosen divisors, the lengths of the periods on either side of a switch, the behaviour of the set and clear views and the readback after ready rises are only shown by the bench's directed scenarios.

// File: rtl/pbdiv_pkg.sv
// Package: shared write-view encoding and register bit positions for the
// peripheral clock-enable divider. Assumes a 32-bit control register.
package pbdiv_pkg;
    typedef enum logic [1:0] {
        VIEW_PLAIN = 2'd0,
        VIEW_SET   = 2'd1,
        VIEW_CLR   = 2'd2,
        VIEW_NONE  = 2'd3
    } wr_view_e;

    localparam int REG_W   = 32;
    localparam int GATE_POS = 15;
    localparam int RDY_POS  = 11;
endpackage

// File: rtl/pbdiv_regs.sv
// Module: control register with plain/set/clear write views and the
// divisor-change handshake. Assumes chg_done_i pulses for one cycle at the
// end of a counter period; a pending change is never overwritten.
module pbdiv_regs
    import pbdiv_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_unlock_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             chg_done_i,
    output logic [DIV_W-1:0] field_o,
    output logic             gate_o,
    output logic             pend_o
);
    logic [DIV_W-1:0] field_q, field_nx;
    logic             gate_q, gate_nx;
    logic             pend_q;
    logic             field_take;

    // Compute the candidate field and gate from the selected write view.
    always_comb begin
        field_nx = field_q;
        gate_nx  = gate_q;
        unique case (wr_view_e'(wr_addr_i))
            VIEW_PLAIN: begin
                field_nx = wr_data_i[DIV_W-1:0];
                gate_nx  = wr_data_i[GATE_POS];
            end
            VIEW_SET: begin
                field_nx = field_q | wr_data_i[DIV_W-1:0];
                gate_nx  = gate_q | wr_data_i[GATE_POS];
            end
            VIEW_CLR: begin
                field_nx = field_q & ~wr_data_i[DIV_W-1:0];
                gate_nx  = gate_q & ~wr_data_i[GATE_POS];
            end
            default: begin
                field_nx = field_q;
                gate_nx  = gate_q;
            end
        endcase
    end

    // A divisor change is taken only when unlocked and no change is pending.
    assign field_take = wr_en_i && sys_unlock_i && !pend_q && (field_nx != field_q);

    // Update gate, divisor field and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            gate_q  <= 1'b1;
            pend_q  <= 1'b0;
        end else begin
            if (wr_en_i) gate_q <= gate_nx;
            if (field_take) begin
                field_q <= field_nx;
                pend_q  <= 1'b1;
            end else if (chg_done_i) begin
                pend_q  <= 1'b0;
            end
        end
    end

    assign field_o = field_q;
    assign gate_o  = gate_q;
    assign pend_o  = pend_q;
endmodule

// File: rtl/pbdiv_counter.sv
// Module: period counter. Counts 0..active divisor and flags the last cycle
// of each period; a pending divisor is loaded only on that last cycle, so
// no period is ever cut short. Assumes field_i is stable while pend_i is high.
module pbdiv_counter #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] field_i,
    input  logic             pend_i,
    output logic             last_o,
    output logic             load_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] act_q;

    assign last_o = (cnt_q == act_q);
    assign load_o = last_o && pend_i;

    // Advance the counter, wrapping and loading a new ratio at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (last_o) begin
            cnt_q <= '0;
            if (pend_i) act_q <= field_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pbdiv_top.sv
// Module: peripheral bus clock-enable divider top. Joins the control
// register to the period counter, gates the pulse and assembles readback.
// Assumes a single clock domain and synchronous active-low reset.
module pbdiv_top
    import pbdiv_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_unlock_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [31:0]      wr_data_i,
    output logic [31:0]      rd_data_o,
    output logic             clk_en_o
);
    logic [DIV_W-1:0] field;
    logic             gate;
    logic             pend;
    logic             last;
    logic             load;

    pbdiv_regs #(.DIV_W(DIV_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_unlock_i(sys_unlock_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .chg_done_i  (load),
        .field_o     (field),
        .gate_o      (gate),
        .pend_o      (pend)
    );

    pbdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .field_i(field),
        .pend_i (pend),
        .last_o (last),
        .load_o (load)
    );

    // Gate the period-end pulse and build the readback word.
    always_comb begin
        clk_en_o                 = last && gate;
        rd_data_o                = '0;
        rd_data_o[DIV_W-1:0]     = field;
        rd_data_o[RDY_POS]       = !pend;
        rd_data_o[GATE_POS]      = gate;
    end
endmodule

// File: rtl/pbdiv_chk.sv
// Module: assertion checker for pbdiv_top, watching its ports only.
// Assumes the default register layout from pbdiv_pkg.
module pbdiv_chk
    import pbdiv_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_unlock_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [31:0]      wr_data_i,
    input logic [31:0]      rd_data_o,
    input logic             clk_en_o
);
    localparam int GAP_W   = DIV_W + 1;
    localparam int MAX_GAP = (1 << DIV_W) - 1;

    logic [GAP_W-1:0] gap_q;
    logic             rdy;
    logic             gate;
    logic [DIV_W-1:0] field;

    assign rdy   = rd_data_o[RDY_POS];
    assign gate  = rd_data_o[GATE_POS];
    assign field = rd_data_o[DIV_W-1:0];

    // Count idle cycles since the last pulse while the gate is set.
    always_ff @(posedge clk) begin
        if (!rst_n || clk_en_o || !gate) gap_q <= '0;
        else if (gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + 1'b1;
    end

    AST_GATE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> !clk_en_o); // R3

    AST_BUSY_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> (field == $past(field))); // R5

    AST_LOCKED_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_unlock_i |=> (field == $past(field))); // R6

    AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd0 && sys_unlock_i && rdy &&
         wr_data_i[DIV_W-1:0] != field) |=> !rdy); // R4

    AST_PULSE_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_W'(MAX_GAP)); // R2
endmodule

bind pbdiv_top pbdiv_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_unlock_i(sys_unlock_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .clk_en_o    (clk_en_o)
);

// File: tb/pbdiv_top_tb.sv
// Directed bench for pbdiv_top: one task per scenario, each checking itself.
module pbdiv_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_unlock_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = 2'd0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        clk_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbdiv_top u_dut (
        .clk(clk), .rst_n(rst_n), .sys_unlock_i(sys_unlock_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .clk_en_o(clk_en_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One write, issued at a negedge; returns at the following negedge.
    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0; wr_addr_i = 2'd0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400 && !rd_data_o[11]; i++) @(negedge clk);
    endtask

    // Advance to the next fresh pulse, sampled at a negedge.
    task automatic next_pulse();
        @(negedge clk);
        for (int i = 0; i < 400 && !clk_en_o; i++) @(negedge clk);
    endtask

    task automatic measure_gap(output int g);
        next_pulse();
        g = 0;
        do begin @(negedge clk); g++; end while (!clk_en_o && g < 400);
    endtask

    task automatic t_reset();
        check("R1 reset readback", rd_data_o, 32'h0000_8800);
        for (int i = 0; i < 4; i++) begin
            check("R1 pulse every cycle", clk_en_o, 1);
            @(negedge clk);
        end
    endtask

    task automatic t_divide(input int f);
        int g;
        do_write(2'd0, 32'h0000_8000 | f);
        wait_ready();
        check("R4 readback after ready", rd_data_o, 32'h0000_8800 | f);
        measure_gap(g);
        check("R2 pulse spacing", g, f + 1);
        measure_gap(g);
        check("R2 pulse spacing repeat", g, f + 1);
    endtask

    task automatic t_switch();
        int g;
        do_write(2'd0, 32'h0000_8009);
        wait_ready();
        next_pulse();
        g = 0;
        repeat (3) begin @(negedge clk); g++; end
        do_write(2'd0, 32'h0000_8002);
        g++;
        check("R4 ready low after change", rd_data_o[11], 0);
        do_write(2'd0, 32'h0000_8805);
        g++;
        check("R5 busy write field kept", rd_data_o[6:0], 2);
        check("R9 ready not writable", rd_data_o[11], 0);
        while (!clk_en_o && g < 400) begin @(negedge clk); g++; end
        check("R7 period at switch keeps old length", g, 10);
        check("R4 ready still low at old period end", rd_data_o[11], 0);
        g = 0;
        do begin @(negedge clk); g++; end while (!clk_en_o && g < 400);
        check("R7 first new period", g, 3);
        check("R4 ready high and field exact", rd_data_o, 32'h0000_8802);
    endtask

    task automatic t_lock();
        sys_unlock_i = 1'b0;
        do_write(2'd0, 32'h0000_8005);
        check("R6 locked write field kept", rd_data_o[6:0], 2);
        check("R6 locked write ready high", rd_data_o[11], 1);
        sys_unlock_i = 1'b1;
    endtask

    task automatic t_alias();
        int g;
        int hits;
        do_write(2'd1, 32'h0000_0004);
        wait_ready();
        check("R8 set view", rd_data_o, 32'h0000_8806);
        do_write(2'd2, 32'h0000_8002);
        wait_ready();
        check("R8 clear view", rd_data_o, 32'h0000_0804);
        hits = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (clk_en_o) hits++;
        end
        check("R3 gated output stays low", hits, 0);
        do_write(2'd3, 32'h0000_807F);
        check("R8 view 3 no effect", rd_data_o, 32'h0000_0804);
        do_write(2'd1, 32'h0000_8000);
        check("R8 set view gate only", rd_data_o, 32'h0000_8804);
        measure_gap(g);
        check("R3 pulses resume", g, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide(3);
        t_divide(127);
        t_divide(0);
        t_divide(1);
        t_switch();
        t_lock();
        t_alias();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule